// File: doc/BRIEF.md
# SPI Chip-Select Generator

This block produces the chip-select pins of an SPI master that serves up to four devices. A 2-bit target field picks one line. The other three lines sit at their inactive level. In automatic mode the chosen line is asserted while the transfer engine reports a burst in progress and released when that burst ends. In manual mode the chosen line follows a level bit written by software, and the engine's busy indication is not used.

A single polarity bit sets which level counts as active. Setting it makes the lines active-low. The bit does more than invert the targeted line: it also sets the idle level of every line that is not targeted, in both modes. All four pins come from flip-flops, so each one changes only at a clock edge and one cycle after the inputs that caused the change.

Top module: `spi_csel_gen`

## Requirements
- R1: While reset is asserted, and in the cycle after it, all chip-select outputs are at `RESET_LEVEL` (default 1, high).
- R2: The 2-bit field `cs_sel` picks the target: the value k targets output bit k of `cs_out`.
- R3: In manual mode (`cs_manual`=1), the targeted line takes the value of `cs_level` (1 = high, 0 = low).
- R4: Every line that is not targeted idles high when `cs_act_low`=1 and low when `cs_act_low`=0, in both manual and automatic mode.
- R5: In automatic mode (`cs_manual`=0), while `xfer_busy`=1 the targeted line is at its active level: low if `cs_act_low`=1, high otherwise.
- R6: In automatic mode, while `xfer_busy`=0 the targeted line is at its inactive level, which is the same as the idle level of R4.
- R7: When `cs_sel` changes, the line that was targeted returns to its inactive level on the same clock edge at which the newly targeted line takes its new value.
- R8: Outputs are registered. They reflect the inputs sampled at the previous rising edge and do not respond to input changes between edges.
- R9: In manual mode, `xfer_busy` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_sel | input | 2 | Index of the targeted chip-select line |
| cs_manual | input | 1 | 1 = software drives the targeted line, 0 = the line follows the burst |
| cs_level | input | 1 | Level for the targeted line in manual mode |
| cs_act_low | input | 1 | 1 = chip-selects are active-low and idle high |
| xfer_busy | input | 1 | Burst in progress, from the transfer engine |
| cs_out | output | 4 | Registered chip-select pins |

## Verification
Two things can happen on the same edge: the target moves to another line, and the busy indication (or the manual level) changes. In that case the old line must be released on exactly the edge at which the new line is asserted. The bench provokes this by changing `cs_sel` together with `xfer_busy` or `cs_level` in one cycle, under both polarities. It judges the result by comparing all four pins against an independent model one edge later. It also checks, before that edge, that the pins still hold their previous value.

// File: rtl/spi_csel_pkg.sv
package spi_csel_pkg;

    localparam int CS_COUNT = 4;
    localparam int CS_SEL_W = $clog2(CS_COUNT);

    typedef struct packed {
        logic [CS_SEL_W-1:0] target;
        logic                manual;
        logic                level;
        logic                act_low;
    } csel_cfg_t;

    typedef enum logic [1:0] {
        LANE_IDLE   = 2'd0,
        LANE_MANUAL = 2'd1,
        LANE_AUTO   = 2'd2
    } lane_mode_e;

    // Level of a line that is not asserted: high for active-low devices.
    function automatic logic idle_level(input logic act_low);
        return act_low;
    endfunction

    function automatic logic assert_level(input logic act_low);
        return ~act_low;
    endfunction

endpackage

// File: rtl/spi_csel_decode.sv
module spi_csel_decode #(
    parameter int N_CS  = 4,
    parameter int SEL_W = $clog2(N_CS)
) (
    input  logic [SEL_W-1:0] sel,
    output logic [N_CS-1:0]  hit
);
    for (genvar i = 0; i < N_CS; i++) begin : g_hit
        assign hit[i] = (sel == SEL_W'(i));
    end
endmodule

// File: rtl/spi_csel_lane.sv
module spi_csel_lane
    import spi_csel_pkg::*;
(
    input  logic      hit,
    input  csel_cfg_t cfg,
    input  logic      busy,
    output logic      nxt
);
    lane_mode_e mode;

    always_comb begin
        if (!hit)
            mode = LANE_IDLE;
        else if (cfg.manual)
            mode = LANE_MANUAL;
        else
            mode = LANE_AUTO;
    end

    always_comb begin
        unique case (mode)
            LANE_MANUAL: nxt = cfg.level;
            LANE_AUTO:   nxt = busy ? assert_level(cfg.act_low) : idle_level(cfg.act_low);
            default:     nxt = idle_level(cfg.act_low);
        endcase
    end
endmodule

// File: rtl/spi_csel_reg.sv
module spi_csel_reg #(
    parameter int          N_CS      = 4,
    parameter logic        RST_LEVEL = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_CS-1:0] d,
    output logic [N_CS-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= {N_CS{RST_LEVEL}};
        else
            q <= d;
    end
endmodule

// File: rtl/spi_csel_gen.sv
module spi_csel_gen
    import spi_csel_pkg::*;
#(
    parameter logic RESET_LEVEL = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [CS_SEL_W-1:0] cs_sel,
    input  logic                cs_manual,
    input  logic                cs_level,
    input  logic                cs_act_low,
    input  logic                xfer_busy,
    output logic [CS_COUNT-1:0] cs_out
);
    csel_cfg_t           cfg;
    logic [CS_COUNT-1:0] hit;
    logic [CS_COUNT-1:0] nxt;

    assign cfg = '{target: cs_sel, manual: cs_manual, level: cs_level, act_low: cs_act_low};

    spi_csel_decode #(.N_CS(CS_COUNT), .SEL_W(CS_SEL_W)) u_dec (
        .sel (cfg.target),
        .hit (hit)
    );

    for (genvar i = 0; i < CS_COUNT; i++) begin : g_lane
        spi_csel_lane u_lane (
            .hit  (hit[i]),
            .cfg  (cfg),
            .busy (xfer_busy),
            .nxt  (nxt[i])
        );
    end

    spi_csel_reg #(.N_CS(CS_COUNT), .RST_LEVEL(RESET_LEVEL)) u_reg (
        .clk (clk),
        .rst (rst),
        .d   (nxt),
        .q   (cs_out)
    );
endmodule

// File: rtl/spi_csel_gen_chk.sv
module spi_csel_gen_chk #(
    parameter int N     = 4,
    parameter int SEL_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic [SEL_W-1:0] cs_sel,
    input logic             cs_manual,
    input logic             cs_level,
    input logic             cs_act_low,
    input logic             xfer_busy,
    input logic [N-1:0]     cs_out
);
    localparam logic [N-1:0] ONE = 1;

    // R4 R7
    idle_lines_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((cs_out ^ {N{$past(cs_act_low)}}) & ~(ONE << $past(cs_sel))) == '0);

    // R3
    manual_level_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cs_manual)) |-> cs_out[$past(cs_sel)] == $past(cs_level));

    // R5
    auto_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(cs_manual) && $past(xfer_busy))
            |-> cs_out[$past(cs_sel)] == !$past(cs_act_low));

    // R6
    auto_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(cs_manual) && !$past(xfer_busy))
            |-> cs_out[$past(cs_sel)] == $past(cs_act_low));

    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $stable(cs_sel) && $stable(cs_manual) && $stable(cs_level)
         && $stable(cs_act_low) && $stable(xfer_busy)) |=> $stable(cs_out));
endmodule

bind spi_csel_gen spi_csel_gen_chk #(.N(spi_csel_pkg::CS_COUNT), .SEL_W(spi_csel_pkg::CS_SEL_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cs_sel     (cs_sel),
    .cs_manual  (cs_manual),
    .cs_level   (cs_level),
    .cs_act_low (cs_act_low),
    .xfer_busy  (xfer_busy),
    .cs_out     (cs_out)
);

// File: tb/spi_csel_gen_test.sv
module spi_csel_gen_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] cs_sel = '0;
    logic       cs_manual = 1'b0;
    logic       cs_level = 1'b0;
    logic       cs_act_low = 1'b1;
    logic       xfer_busy = 1'b0;
    logic [3:0] cs_out;

    int checks = 0;
    int errors = 0;
    logic [3:0] prev_exp = 4'hF;

    logic [3:0] exp_q[$];
    string      tag_q[$];

    spi_csel_gen uut (
        .clk        (clk),
        .rst        (rst),
        .cs_sel     (cs_sel),
        .cs_manual  (cs_manual),
        .cs_level   (cs_level),
        .cs_act_low (cs_act_low),
        .xfer_busy  (xfer_busy),
        .cs_out     (cs_out)
    );

    always #5 clk = ~clk;

    function automatic logic [3:0] model(input logic [1:0] s, input logic m,
                                         input logic l, input logic al, input logic b);
        logic [3:0] v;
        v = al ? 4'hF : 4'h0;
        if (m) v[s] = l;
        else   v[s] = b ? ~al : al;
        return v;
    endfunction

    task automatic compare(input logic [3:0] exp, input string tag);
        checks++;
        if (cs_out !== exp) begin
            errors++;
            $display("FAIL %s: cs_out=%b expected=%b", tag, cs_out, exp);
        end
    endtask

    // Driver: applies one input set and pushes the expected result.
    task automatic drive(input logic [1:0] s, input logic m, input logic l,
                         input logic al, input logic b, input string tag);
        logic [3:0] e;
        @(negedge clk);
        cs_sel = s; cs_manual = m; cs_level = l; cs_act_low = al; xfer_busy = b;
        e = model(s, m, l, al, b);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        #1;
        compare(prev_exp, "R8 output held until edge");
        prev_exp = e;
    endtask

    // Monitor: compares after each rising edge.
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            logic [3:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            compare(e, t);
        end
    end

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: cs_out=%b expected=completion", cs_out);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        compare(4'hF, "R1 reset level");
        rst = 1'b0;
        @(posedge clk); #2;
        compare(4'hF, "R1 reset level held first cycle");

        for (int k = 0; k < 4; k++) begin
            drive(2'(k), 1'b1, 1'b0, 1'b1, 1'b0, "R2 R3 manual low active-low");
            drive(2'(k), 1'b1, 1'b1, 1'b1, 1'b0, "R3 manual high");
        end
        drive(2'd2, 1'b1, 1'b1, 1'b0, 1'b0, "R4 idle low polarity clear");
        drive(2'd2, 1'b1, 1'b0, 1'b0, 1'b0, "R3 R4 manual low polarity clear");
        drive(2'd2, 1'b1, 1'b0, 1'b0, 1'b1, "R9 busy ignored manual");
        drive(2'd1, 1'b1, 1'b1, 1'b1, 1'b1, "R9 busy ignored manual active-low");

        drive(2'd0, 1'b0, 1'b0, 1'b1, 1'b0, "R6 auto idle active-low");
        drive(2'd0, 1'b0, 1'b0, 1'b1, 1'b1, "R5 auto busy active-low");
        drive(2'd3, 1'b0, 1'b0, 1'b1, 1'b1, "R7 select change during burst");
        drive(2'd1, 1'b0, 1'b0, 1'b1, 1'b0, "R6 R7 select change with burst end");
        drive(2'd1, 1'b0, 1'b0, 1'b0, 1'b1, "R4 R5 auto busy polarity clear");
        drive(2'd2, 1'b0, 1'b0, 1'b0, 1'b1, "R7 select change polarity clear");
        drive(2'd2, 1'b0, 1'b0, 1'b0, 1'b0, "R6 auto idle polarity clear");
        drive(2'd3, 1'b1, 1'b1, 1'b0, 1'b0, "R7 switch to manual and target together");
        drive(2'd0, 1'b0, 1'b1, 1'b1, 1'b1, "R5 R7 back to auto, polarity flip");

        repeat (3) @(posedge clk);
        #3;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule